// File: doc/BRIEF.md
# Table-Driven DMA Channel Scheduler

This block decides which DMA channel, and in which direction, gets the next service slot. Software loads a table of 8-bit slot entries, four per 32-bit word, and then writes a control word that sets the index of the last slot in use and turns the scheduler on. The scheduler walks the table from slot 0 up to that last index. It presents each slot as a grant made of a channel number, a receive/transmit flag and a valid strobe, and it wraps back to slot 0 after the last slot.

A downstream consumer takes a grant by raising accept while valid is high. The grant then moves to the next slot. The grant order is therefore whatever software writes, for example TX and RX slots of neighbouring channels interleaved. Software reaches the control word and the table through a plain single-cycle register port. Read data is registered and is available one clock after the read strobe. Software is expected to turn the scheduler off before it rewrites the table.

Top module: `tsched_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), grant_valid is 0, and the control word and every table word read back as 0.
- R2: While the enable bit (bit 31 of the control word at byte offset 0x000) is 0, grant_valid stays 0.
- R3: Table word w (0 to TBL_WORDS-1) sits at byte offset 0x800 + 4*w. It is written by reg_wr and read back unchanged. A read of any other offset except 0x000 returns 0, and a write to such an offset changes nothing. reg_rdata updates on the clock edge that samples reg_rd.
- R4: Slot k is held in table word k/4 at bits 8*(k%4)+7 down to 8*(k%4). The grant of slot k carries grant_chan = entry bits 4:0 and grant_rx = entry bit 7 (1 = receive, 0 = transmit). Entry bits 6:5 have no effect on the grant.
- R5: Once enabled with last index L, grant_valid rises on the second clock edge after the control write. Accepted grants then follow slots 0, 1, …, L, 0, 1, … in that order.
- R6: While grant_valid is high and grant_accept is low, grant_valid, grant_chan and grant_rx hold their values and the slot does not advance.
- R7: A control write that clears the enable bit makes grant_valid low from the second clock edge after the write. The next enable starts again from slot 0.
- R8: The control word reads back with bit 31 = enable, bits IDX_W-1:0 = last index (IDX_W = log2(4*TBL_WORDS), 6 by default), and all other bits 0.
- R9: With last index 0, every accepted grant repeats slot 0 and grant_valid stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| grant_valid | output | 1 | Grant present |
| grant_chan | output | 5 | Granted channel number |
| grant_rx | output | 1 | Granted direction, 1 = receive |
| grant_accept | input | 1 | Consumer takes the current grant |

## Verification
If the slot pointer is corrupted, the next grant shows a channel or direction that does not belong in the expected table order. The bench sees this on the first grant after the fault, because every slot holds a distinct byte computed arithmetically. A wrong wrap point or a pointer that fails to reset shows up as an out-of-order grant right after slot L, or on the first grant after re-enable. A wrong enable or hold state shows as valid appearing while the scheduler is off, or as the grant changing while accept is low, within one cycle.

// File: rtl/tsched_pkg.sv
// Package: shared constants for the table-driven scheduler.
// Assumes a 32-bit register word holding four 8-bit slot entries.
package tsched_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ENTRY_W  = 8;
    localparam int unsigned CHAN_W   = 5;
    localparam int unsigned DIR_BIT  = 7;
    localparam int unsigned EN_BIT   = 31;
    localparam int unsigned CTRL_OFS = 32'h000;
    localparam int unsigned TBL_BASE = 32'h800;

    typedef struct packed {
        logic              rx;
        logic [CHAN_W-1:0] chan;
    } grant_t;
endpackage

// File: rtl/tsched_regs.sv
// Module: tsched_regs
// Holds the control word (enable and last index) and the slot table, and
// serves the single-cycle register port with registered read data.
// Assumes TBL_WORDS is a power of two, at least 2.
module tsched_regs
    import tsched_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned TBL_WORDS = 16,
    localparam int unsigned IDX_W    = $clog2(TBL_WORDS * 4),
    localparam int unsigned WI_W     = $clog2(TBL_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic                        en,
    output logic [IDX_W-1:0]            last_idx,
    output logic [TBL_WORDS*WORD_W-1:0] tbl_flat
);
    localparam logic [ADDR_W-3:0] WORDS_LIM = (ADDR_W-2)'(TBL_WORDS);

    logic [WORD_W-1:0] tbl [TBL_WORDS];
    logic [ADDR_W-1:0] ofs;
    logic              is_ctrl;
    logic              tbl_hit;
    logic [WI_W-1:0]   wi;
    logic [WORD_W-1:0] rd_mux;
    logic              unused_wdata;

    assign ofs     = reg_addr - TBL_BASE[ADDR_W-1:0];
    assign is_ctrl = (reg_addr == CTRL_OFS[ADDR_W-1:0]);
    assign tbl_hit = (reg_addr >= TBL_BASE[ADDR_W-1:0]) && (ofs[1:0] == 2'b00)
                     && (ofs[ADDR_W-1:2] < WORDS_LIM);
    assign wi      = ofs[WI_W+1:2];
    assign unused_wdata = ^reg_wdata[EN_BIT-1:IDX_W];

    // Control word: enable flag and last slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            last_idx <= '0;
        end else if (reg_wr && is_ctrl) begin
            en       <= reg_wdata[EN_BIT];
            last_idx <= reg_wdata[IDX_W-1:0];
        end
    end

    // One storage word per table entry group, flattened for the selector.
    for (genvar g = 0; g < TBL_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl[g] <= '0;
            else if (reg_wr && tbl_hit && (wi == WI_W'(g)))
                tbl[g] <= reg_wdata;
        end
        assign tbl_flat[g*WORD_W +: WORD_W] = tbl[g];
    end

    // Read multiplexer over control and table space.
    always_comb begin
        rd_mux = '0;
        if (is_ctrl)
            rd_mux = {en, {(EN_BIT-IDX_W){1'b0}}, last_idx};
        else if (tbl_hit)
            rd_mux = tbl[wi];
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    // R8
    ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && is_ctrl) |=> (reg_rdata[EN_BIT-1:IDX_W] == '0));
    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !is_ctrl && !tbl_hit) |=> (reg_rdata == '0));
endmodule

// File: rtl/tsched_seq.sv
// Module: tsched_seq
// Slot pointer and valid strobe. Advances on an accepted grant, wraps after
// the last index, and clears when the scheduler is disabled.
// Assumes the table is not rewritten while enabled.
module tsched_seq #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             accept,
    output logic             valid,
    output logic [IDX_W-1:0] ptr
);
    // Pointer and valid state update.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            valid <= 1'b0;
            ptr   <= '0;
        end else begin
            valid <= 1'b1;
            if (valid && accept)
                ptr <= (ptr >= last_idx) ? '0 : ptr + 1'b1;
        end
    end

    // R2
    off_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !valid);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !accept && en) |=> (valid && $stable(ptr)));
    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && accept && en && ptr >= last_idx) |=> (ptr == '0));
    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && accept && en && ptr < last_idx) |=> (ptr == $past(ptr) + 1'b1));
    // R7
    off_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ptr == '0));
endmodule

// File: rtl/tsched_pick.sv
// Module: tsched_pick
// Selects the slot entry addressed by the pointer and decodes its channel and
// direction. Reserved entry bits are dropped.
module tsched_pick
    import tsched_pkg::*;
#(
    parameter int unsigned TBL_WORDS = 16,
    localparam int unsigned IDX_W    = $clog2(TBL_WORDS * 4)
) (
    input  logic [TBL_WORDS*WORD_W-1:0] tbl_flat,
    input  logic [IDX_W-1:0]            ptr,
    output grant_t                      grant
);
    logic [WORD_W-1:0]  word;
    logic [ENTRY_W-1:0] entry;
    logic               unused_rsvd;

    // Word then byte selection from the pointer.
    always_comb begin
        word  = tbl_flat[ptr[IDX_W-1:2]*WORD_W +: WORD_W];
        entry = word[ptr[1:0]*ENTRY_W +: ENTRY_W];
    end

    assign grant.chan  = entry[CHAN_W-1:0];
    assign grant.rx    = entry[DIR_BIT];
    assign unused_rsvd = ^entry[DIR_BIT-1:CHAN_W];
endmodule

// File: rtl/tsched_top.sv
// Module: tsched_top
// Table-driven channel scheduler: register bank, slot sequencer and entry
// decoder. Grants one channel and direction per slot.
module tsched_top
    import tsched_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned TBL_WORDS = 16,
    localparam int unsigned IDX_W    = $clog2(TBL_WORDS * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              grant_valid,
    output logic [4:0]        grant_chan,
    output logic              grant_rx,
    input  logic              grant_accept
);
    logic                        en;
    logic [IDX_W-1:0]            last_idx;
    logic [IDX_W-1:0]            ptr;
    logic [TBL_WORDS*WORD_W-1:0] tbl_flat;
    grant_t                      grant;

    tsched_regs #(.ADDR_W(ADDR_W), .TBL_WORDS(TBL_WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en(en), .last_idx(last_idx), .tbl_flat(tbl_flat)
    );

    tsched_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .last_idx(last_idx),
        .accept(grant_accept), .valid(grant_valid), .ptr(ptr)
    );

    tsched_pick #(.TBL_WORDS(TBL_WORDS)) u_pick (
        .tbl_flat(tbl_flat), .ptr(ptr), .grant(grant)
    );

    assign grant_chan = grant.chan;
    assign grant_rx   = grant.rx;
endmodule

// File: tb/tsched_top_bench.sv
module tsched_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        grant_valid, grant_rx, grant_accept = 1'b0;
    logic [4:0]  grant_chan;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    tsched_top u_tsched_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .grant_valid(grant_valid), .grant_chan(grant_chan), .grant_rx(grant_rx),
        .grant_accept(grant_accept)
    );

    function automatic logic [7:0] eb(int e);
        return 8'((e * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] ew(int w);
        return {eb(4*w+3), eb(4*w+2), eb(4*w+1), eb(4*w)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic chk_grant(int e, string req);
        chk(grant_valid && grant_chan == eb(e)[4:0] && grant_rx == eb(e)[7], req,
            {24'd0, grant_valid, grant_rx, 1'b0, grant_chan},
            {24'd0, 1'b1, eb(e)[7], 1'b0, eb(e)[4:0]});
    endtask

    // Enable with last index L, take n accepted grants, then disable.
    task automatic run_seq(int L, int n, string req);
        int exp = 0;
        grant_accept = 1'b1;
        wr(12'h000, 32'h8000_0000 | L);
        chk(!grant_valid, "R5 valid not yet", {31'd0, grant_valid}, 0);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            chk_grant(exp, req);
            exp = (exp == L) ? 0 : exp + 1;
            @(negedge clk);
        end
        wr(12'h000, 32'h0);
        @(negedge clk);
        chk(!grant_valid, "R7 valid drop", {31'd0, grant_valid}, 0);
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0]  hc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!grant_valid, "R1 valid", {31'd0, grant_valid}, 0);
        rd(12'h000, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(12'h804, d); chk(d == 0, "R1 table", d, 0);
        // R3 table load and readback
        for (int w = 0; w < 16; w++) wr(12'h800 + 12'(4*w), ew(w));
        wr(12'h840, 32'hDEAD_BEEF);
        wr(12'h802, 32'h1234_5678);
        for (int w = 0; w < 16; w++) begin
            rd(12'h800 + 12'(4*w), d); chk(d == ew(w), "R3 readback", d, ew(w));
        end
        rd(12'h840, d); chk(d == 0, "R3 unmapped 0x840", d, 0);
        rd(12'h802, d); chk(d == 0, "R3 unaligned", d, 0);
        rd(12'h004, d); chk(d == 0, "R3 unmapped 0x004", d, 0);
        // R8 control readback
        wr(12'h000, 32'h7FFF_FFC5);
        rd(12'h000, d); chk(d == 32'h0000_0005, "R8 ctrl off", d, 32'h5);
        // R2 disabled: no grants
        grant_accept = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); chk(!grant_valid, "R2 off", {31'd0, grant_valid}, 0);
        end
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, d); chk(d == 32'h8000_003F, "R8 ctrl on", d, 32'h8000_003F);
        wr(12'h000, 32'h0);
        @(negedge clk);
        // R4 R5 R9 sequences
        run_seq(0, 6, "R9 single slot");
        run_seq(5, 15, "R5 wrap L=5");
        run_seq(59, 130, "R4 decode L=59");
        run_seq(63, 140, "R5 full table");
        // R7 partial run then restart at slot 0
        grant_accept = 1'b1;
        wr(12'h000, 32'h8000_0009);
        repeat (5) @(negedge clk);
        wr(12'h000, 32'h0);
        @(negedge clk);
        chk(!grant_valid, "R7 off", {31'd0, grant_valid}, 0);
        run_seq(9, 12, "R7 restart");
        // R6 hold without accept
        grant_accept = 1'b0;
        wr(12'h000, 32'h8000_0007);
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            chk_grant(0, "R6 hold slot0"); @(negedge clk);
        end
        grant_accept = 1'b1;
        @(negedge clk);
        grant_accept = 1'b0;
        hc = {3'd0, grant_chan};
        for (int i = 0; i < 4; i++) begin
            chk_grant(1, "R6 hold slot1"); @(negedge clk);
        end
        chk(grant_chan == hc[4:0], "R6 stable", {27'd0, grant_chan}, {24'd0, hc});
        wr(12'h000, 32'h0);
        @(negedge clk);
        chk(!grant_valid, "R7 final off", {31'd0, grant_valid}, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule